// File: doc/BRIEF.md
# Filtered Edge Timestamp Capture

This block timestamps edges on an asynchronous input pin. A 16-bit count value from a free-running counter outside the block arrives on an input. When a qualifying edge arrives on the pin, the block copies that value into a capture register. At the same time it raises an event flag for exactly one clock cycle.

The pin first passes through a two-flop synchronizer. It then enters a level filter that holds the last accepted pin level. With the filter off, every synchronized transition is accepted at once. With the filter on, the new level must appear in four successive clock samples before it is accepted. Shorter pulses are discarded.

An edge-polarity control chooses whether accepted falling or rising transitions produce a capture. A capture enable blocks captures altogether while it is low, but the filter keeps tracking the pin.

Top module: `edge_stamp_unit`

## Requirements
- R1: With `edge_sel` = 0, an accepted high-to-low transition of the pin produces a capture.
- R2: With `edge_sel` = 1, an accepted low-to-high transition produces a capture. Accepted transitions of the other polarity produce no event and leave `cap_value` unchanged.
- R3: With `filt_en` = 0, the event is visible after the third rising clock edge following a pin change that settles between two edges. This includes a pin pulse one clock long.
- R4: With `filt_en` = 1, a new level is accepted only on the fourth successive clock sample showing it. The event is visible after the sixth rising clock edge following the pin change.
- R5: With `filt_en` = 1, a new level lasting three samples or fewer is rejected. It causes no event, and the accepted level stays as it was.
- R6: While `cap_en` = 0, no event is raised and `cap_value` holds its value. The level filter keeps tracking the pin.
- R7: On an event, `cap_value` equals the `count_in` value presented during the clock cycle before the event becomes visible. `cap_value` holds that value until the next event.
- R8: `cap_evt` is high for exactly one clock cycle per capture.
- R9: Reset is synchronous and active-high. It clears `cap_value` to 0 and `cap_evt` to 0, and it takes the synchronized pin level as the accepted level. A pin level held steady through reset therefore causes no event afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the pin is sampled at this rate |
| rst | input | 1 | Synchronous active-high reset |
| cap_pin | input | 1 | Asynchronous capture pin |
| count_in | input | 16 | Value of the external running counter |
| cap_en | input | 1 | 1 allows captures, 0 suppresses them |
| edge_sel | input | 1 | 0 selects falling edges, 1 selects rising edges |
| filt_en | input | 1 | 1 enables the four-sample level filter |
| cap_value | output | 16 | Captured counter value |
| cap_evt | output | 1 | One-cycle capture event flag |

## Verification
The hardest case to reach from the ports is a run of samples that ends exactly one short of the filter threshold. It must be told apart from one that just reaches it. The bench drives the pin on falling clock edges and holds a new level for a counted number of rising edges: three edges for the rejected case and a full transition for the accepted one. It then watches a fixed window and locates the event to the exact edge. Each rejected glitch is followed by a real transition of the same polarity, which shows that the accepted level was not disturbed. Tracking the pin while captures are disabled is checked the same way: a transition made while disabled is followed by a transition of the other polarity after captures are enabled again.

// File: rtl/esu_pkg.sv
`timescale 1ns/1ps
package esu_pkg;
  typedef enum logic {
    POL_FALL = 1'b0,
    POL_RISE = 1'b1
  } edge_pol_e;

  function automatic logic pol_match(input logic new_level, input edge_pol_e pol);
    return (pol == POL_RISE) ? new_level : ~new_level;
  endfunction
endpackage

// File: rtl/esu_sync.sv
`timescale 1ns/1ps
module esu_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) chain_q[0] <= async_i;
      end else begin : g_next
        always_ff @(posedge clk) chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/esu_level_filter.sv
`timescale 1ns/1ps
module esu_level_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic sample_i,
  input  logic filt_en_i,
  output logic level_o,
  output logic change_o,
  output logic new_level_o
);
  localparam int RUN_W = $clog2(FILT_LEN + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(FILT_LEN);
  localparam logic [RUN_W-1:0] RUN_ACC = RUN_W'(FILT_LEN - 1);

  logic             level_q;
  logic             cand_q;
  logic [RUN_W-1:0] run_q;
  logic             accept_raw;
  logic             accept_filt;

  assign accept_raw  = (sample_i != level_q);
  assign accept_filt = (sample_i == cand_q) && (run_q >= RUN_ACC) && (sample_i != level_q);
  assign change_o    = filt_en_i ? accept_filt : accept_raw;
  assign new_level_o = sample_i;
  assign level_o     = level_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= sample_i;
      cand_q  <= sample_i;
      run_q   <= RUN_MAX;
    end else begin
      if (sample_i != cand_q) begin
        cand_q <= sample_i;
        run_q  <= RUN_W'(1);
      end else if (run_q < RUN_MAX) begin
        run_q <= run_q + RUN_W'(1);
      end
      if (change_o) level_q <= sample_i;
    end
  end

  initial begin
    a_r4_len_legal: assert (FILT_LEN >= 2);
  end

  // R5: in filtered mode the newly accepted level was also the previous sample
  a_r5_stable_before_accept: assert property (@(posedge clk) disable iff (rst)
    ($past(filt_en_i) && !$past(rst) && (level_q != $past(level_q))) |-> ($past(cand_q) == level_q));
endmodule

// File: rtl/esu_capture.sv
`timescale 1ns/1ps
module esu_capture
  import esu_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             change_i,
  input  logic             new_level_i,
  input  logic             edge_sel_i,
  input  logic             cap_en_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [CNT_W-1:0] cap_o,
  output logic             evt_o
);
  logic [CNT_W-1:0] cap_q;
  logic             evt_q;
  logic             fire;

  assign fire = change_i && cap_en_i && pol_match(new_level_i, edge_pol_e'(edge_sel_i));

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q <= '0;
      evt_q <= 1'b0;
    end else begin
      evt_q <= fire;
      if (fire) cap_q <= count_i;
    end
  end

  assign cap_o = cap_q;
  assign evt_o = evt_q;

  // R8: no two events in back-to-back cycles
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst) evt_q |=> !evt_q);
  // R6: disabled capture gives no event next cycle
  a_r6_no_evt_disabled: assert property (@(posedge clk) disable iff (rst) !cap_en_i |=> !evt_q);
  // R7: captured value is the count of the previous cycle, and holds otherwise
  a_r7_cap_value: assert property (@(posedge clk) disable iff (rst)
    (evt_q && !$past(rst)) |-> (cap_q == $past(count_i)));
  a_r7_cap_hold: assert property (@(posedge clk) disable iff (rst)
    (!evt_q && !$past(rst)) |-> $stable(cap_q));
  // R2: the edge that fired matches the selected polarity
  a_r2_polarity: assert property (@(posedge clk) disable iff (rst)
    (evt_q && !$past(rst)) |-> ($past(new_level_i) == $past(edge_sel_i)));
endmodule

// File: rtl/edge_stamp_unit.sv
`timescale 1ns/1ps
module edge_stamp_unit #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_pin,
  input  logic [CNT_W-1:0] count_in,
  input  logic             cap_en,
  input  logic             edge_sel,
  input  logic             filt_en,
  output logic [CNT_W-1:0] cap_value,
  output logic             cap_evt
);
  logic pin_sync;
  logic level;
  logic change;
  logic new_level;

  esu_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .async_i(cap_pin),
    .sync_o (pin_sync)
  );

  esu_level_filter #(.FILT_LEN(FILT_LEN)) u_filter (
    .clk        (clk),
    .rst        (rst),
    .sample_i   (pin_sync),
    .filt_en_i  (filt_en),
    .level_o    (level),
    .change_o   (change),
    .new_level_o(new_level)
  );

  esu_capture #(.CNT_W(CNT_W)) u_capture (
    .clk        (clk),
    .rst        (rst),
    .change_i   (change),
    .new_level_i(new_level),
    .edge_sel_i (edge_sel),
    .cap_en_i   (cap_en),
    .count_i    (count_in),
    .cap_o      (cap_value),
    .evt_o      (cap_evt)
  );

  // R9: level steady through reset produces no event in the first cycle after it
  a_r9_quiet_after_reset: assert property (@(posedge clk) $past(rst) |-> !cap_evt);
  // R6: filter keeps tracking while captures are off (accepted level follows the pin unfiltered)
  a_r6_track_disabled: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(filt_en) && !$past(cap_en)) |-> (level == $past(pin_sync)));
endmodule

// File: tb/edge_stamp_unit_tb.sv
`timescale 1ns/1ps
module edge_stamp_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cap_pin = 1'b1;
  logic [15:0] count_in = 16'h1234;
  logic        cap_en = 1'b1;
  logic        edge_sel = 1'b0;
  logic        filt_en = 1'b0;
  logic [15:0] cap_value;
  logic        cap_evt;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] last_cap = 16'h0;

  always #2.5 clk = ~clk;
  always @(posedge clk) count_in <= count_in + 16'd7;

  edge_stamp_unit u_dut (
    .clk(clk), .rst(rst), .cap_pin(cap_pin), .count_in(count_in),
    .cap_en(cap_en), .edge_sel(edge_sel), .filt_en(filt_en),
    .cap_value(cap_value), .cap_evt(cap_evt)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // watch win edges from the current negedge; report first event edge, high count, value
  task automatic watch(input int win, output int first, output int nhigh, output logic [15:0] val);
    logic [15:0] c;
    first = 0; nhigh = 0; val = cap_value;
    for (int i = 1; i <= win; i++) begin
      c = count_in;
      @(posedge clk);
      @(negedge clk);
      if (cap_evt) begin
        nhigh++;
        if (first == 0) begin
          first = i;
          if (cap_value !== c) begin
            n_chk++; n_bad++;
            $display("FAIL R7 actual=%0h expected=%0h", cap_value, c);
          end
          last_cap = c;
        end
      end
    end
    val = cap_value;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect_edge(input logic v, input int lat, input string req);
    int f, h; logic [15:0] val;
    cap_pin = v;
    watch(12, f, h, val);
    check(req, f, lat);
    check({req, " R8"}, h, (lat == 0) ? 0 : 1);
    check({req, " R7"}, int'(val), int'(last_cap));
  endtask

  task automatic t_reset;
    int f, h; logic [15:0] val;
    @(negedge clk);
    check("R9 evt", int'(cap_evt), 0);
    check("R9 cap", int'(cap_value), 0);
    watch(8, f, h, val);
    check("R9 quiet", f, 0);
  endtask

  task automatic t_falling;
    edge_sel = 1'b0; filt_en = 1'b0; idle(2);
    expect_edge(1'b0, 3, "R1 R3 fall");
    expect_edge(1'b1, 0, "R2 rise ignored sel0");
  endtask

  task automatic t_rising;
    edge_sel = 1'b1; idle(2);
    expect_edge(1'b0, 0, "R2 fall ignored sel1");
    expect_edge(1'b1, 3, "R2 rise sel1");
  endtask

  task automatic t_one_cycle_pulse;
    int f, h; logic [15:0] val;
    edge_sel = 1'b0; idle(2);
    cap_pin = 1'b0;
    fork
      begin @(posedge clk); @(negedge clk); cap_pin = 1'b1; end
      watch(12, f, h, val);
    join
    check("R3 one-cycle pulse", f, 3);
    check("R8 pulse width", h, 1);
  endtask

  task automatic t_filter;
    int f, h; logic [15:0] val;
    filt_en = 1'b1; edge_sel = 1'b0; idle(8);
    cap_pin = 1'b0;
    fork
      begin repeat (3) @(posedge clk); @(negedge clk); cap_pin = 1'b1; end
      watch(14, f, h, val);
    join
    check("R5 three-sample glitch rejected", f, 0);
    expect_edge(1'b0, 6, "R4 four samples accepted");
    edge_sel = 1'b1; idle(2);
    cap_pin = 1'b1;
    fork
      begin repeat (2) @(posedge clk); @(negedge clk); cap_pin = 1'b0; end
      watch(14, f, h, val);
    join
    check("R5 two-sample glitch rejected", f, 0);
    expect_edge(1'b1, 6, "R4 filtered rise");
  endtask

  task automatic t_disabled;
    int f, h; logic [15:0] val;
    filt_en = 1'b0; edge_sel = 1'b0; cap_en = 1'b0; idle(2);
    cap_pin = 1'b0;
    watch(12, f, h, val);
    check("R6 no event while disabled", f, 0);
    check("R6 cap held", int'(val), int'(last_cap));
    cap_en = 1'b1; idle(2);
    expect_edge(1'b1, 0, "R6 level tracked while disabled");
    expect_edge(1'b0, 3, "R6 re-enabled fall");
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (6) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_falling();
    t_rising();
    t_one_cycle_pulse();
    t_filter();
    t_disabled();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule